// File: doc/BRIEF.md
# Multithreaded Tree Traversal Step Controller

This block sequences the traversal of a binary spatial tree for many threads at once. Each thread is a packet of four rays. The block keeps, for every thread, a state, the address of the node it works on, a mask of active rays and a private stack. The rays are tested against the child nodes outside this block, and the controller acts on the child-hit flags and the near and far distances that come back. From these it decides whether to fall back to a deferred node, descend into one child, or descend into the closer child and defer the other. Leaves go out to a geometry interface. When a thread must fall back and has nothing deferred, its packet is finished.

Switching between threads costs nothing. A round-robin arbiter issues one ready thread per cycle on a valid/ready node-fetch port. A thread that is waiting for a fetch or for geometry is never issued. The shared stack store has one read port and one write port. It is read only when a thread issues a fall-back, and written only when both children are to be visited.

Top module: `tts_step_ctrl`

## Requirements
- R1: After reset every thread is idle, no fetch, leaf or completion is offered, and all overflow flags are 0.
- R2: A start (tid, root address, active-ray mask) is taken only for an idle thread, and a start for any other thread has no effect. A taken start clears that thread's stack and its overflow flag.
- R3: Among threads that are ready to issue, the arbiter grants the first one after the last granted thread in cyclic order (thread 0 first after reset). A thread that waits on a fetch or on geometry is not eligible. A fetch is taken on fetch_valid && fetch_ready, and the thread then waits for its response.
- R4: A thread that has a known next node issues it with fetch_pop = 0, and fetch_near and fetch_far are all zero.
- R5: A thread that must fall back issues the most recently deferred entry (last in, first out), with fetch_pop = 1 and that entry's address and its per-ray near and far values.
- R6: A thread that is granted for a fall-back while its stack is empty raises done_valid with its tid for that cycle and becomes idle. It needs no fetch_ready, and the arbiter still advances.
- R7: A response for a waiting thread that has resp_leaf = 1 raises geom_valid in the same cycle, with the tid and the address of the fetched node. The thread then waits for geometry.
- R8: A response for an inner node with no active ray hitting either child makes the thread fall back next.
- R9: If active rays hit only one child, the thread next fetches that child and its stack is left unchanged.
- R10: If both children are hit, the thread next fetches the child whose near value for the lowest-numbered active ray is smaller, taking the left child on a tie (ray 0 if no ray is active). The other child's address, near and far values are pushed.
- R11: A push onto a stack that already holds DEPTH entries is dropped and sets that thread's overflow flag, which stays set until the thread is started again.
- R12: geom_done for a thread that waits on geometry makes it fall back next. For any other thread geom_done is ignored.
- R13: Hit flags of rays outside the thread's active mask are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Start a thread |
| start_tid | input | TIDW | Thread to start |
| start_addr | input | AW | Root node address |
| start_mask | input | RAYS | Active-ray mask |
| fetch_valid | output | 1 | Node fetch request |
| fetch_ready | input | 1 | Fetch accepted |
| fetch_tid | output | TIDW | Requesting thread |
| fetch_addr | output | AW | Node address |
| fetch_pop | output | 1 | Request comes from a stack pop |
| fetch_near | output | RAYS*DW | Popped near values, ray 0 in the low bits |
| fetch_far | output | RAYS*DW | Popped far values |
| resp_valid | input | 1 | Fetched node and child-test results |
| resp_tid | input | TIDW | Thread of the response |
| resp_leaf | input | 1 | Node is a leaf |
| resp_left_addr | input | AW | Left child address |
| resp_right_addr | input | AW | Right child address |
| resp_hit_left | input | RAYS | Per-ray left-child hit |
| resp_hit_right | input | RAYS | Per-ray right-child hit |
| resp_near_left | input | RAYS*DW | Per-ray left near distance |
| resp_far_left | input | RAYS*DW | Per-ray left far distance |
| resp_near_right | input | RAYS*DW | Per-ray right near distance |
| resp_far_right | input | RAYS*DW | Per-ray right far distance |
| geom_valid | output | 1 | Leaf handed to geometry |
| geom_tid | output | TIDW | Thread of the leaf |
| geom_addr | output | AW | Leaf node address |
| geom_done_valid | input | 1 | Geometry finished for a thread |
| geom_done_tid | input | TIDW | Thread that geometry finished |
| done_valid | output | 1 | Thread finished |
| done_tid | output | TIDW | Finished thread |
| ovf_flags | output | NTHREADS | Sticky per-thread stack overflow flags |

## Verification
The bench builds the controller with 4 threads, a stack depth of 4, 16-bit addresses and 8-bit distances. With only four threads, the round-robin wrap, skipping of waiting threads and grant contention happen within a few cycles. With a depth of 4, random both-hit responses fill a stack quickly, so dropped pushes and the sticky overflow flag come up many times. About a quarter of the responses use equal near distances, which exercises the left-on-tie rule. Partial and empty ray masks show that hits on inactive rays are ignored.

// File: rtl/tts_pkg.sv
package tts_pkg;

   typedef enum logic [2:0] {
      TS_IDLE       = 3'd0,
      TS_RDY_NODE   = 3'd1,
      TS_RDY_POP    = 3'd2,
      TS_WAIT_FETCH = 3'd3,
      TS_WAIT_GEOM  = 3'd4
   } tstate_e;

   typedef enum logic [1:0] {
      ACT_POP  = 2'd0,
      ACT_DESC = 2'd1,
      ACT_PUSH = 2'd2
   } step_e;

endpackage

// File: rtl/tts_rr_arb.sv
module tts_rr_arb #(
   parameter int N       = 64,
   parameter bit ROUND_R = 1'b1,
   localparam int IW     = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   input  logic          adv,
   output logic          gnt_valid,
   output logic [IW-1:0] gnt_idx
);

   generate
      if (ROUND_R) begin : g_rr
         logic [IW-1:0] last_q;

         always_comb begin
            int idx;
            gnt_valid = 1'b0;
            gnt_idx   = '0;
            for (int k = N; k >= 1; k--) begin
               idx = (int'(last_q) + k) % N;
               if (req[idx]) begin
                  gnt_valid = 1'b1;
                  gnt_idx   = IW'(idx);
               end
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               last_q <= IW'(N - 1);
            else if (adv && gnt_valid)
               last_q <= gnt_idx;
         end
      end else begin : g_fixed
         always_comb begin
            gnt_valid = 1'b0;
            gnt_idx   = '0;
            for (int k = N - 1; k >= 0; k--) begin
               if (req[k]) begin
                  gnt_valid = 1'b1;
                  gnt_idx   = IW'(k);
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/tts_thread_stack.sv
module tts_thread_stack #(
   parameter int NTHREADS = 64,
   parameter int DEPTH    = 32,
   parameter int EW       = 288,
   localparam int TIDW    = $clog2(NTHREADS),
   localparam int LW      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int SPW     = $clog2(DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [TIDW-1:0]     rd_tid,
   input  logic                pop_en,
   output logic [EW-1:0]       rd_entry,
   output logic                rd_empty,
   input  logic                wr_en,
   input  logic [TIDW-1:0]     wr_tid,
   input  logic [EW-1:0]       wr_entry,
   input  logic                clr_en,
   input  logic [TIDW-1:0]     clr_tid,
   output logic [NTHREADS-1:0] ovf
);

   logic [EW-1:0]       mem_q [NTHREADS][DEPTH];
   logic [SPW-1:0]      sp_q  [NTHREADS];
   logic [NTHREADS-1:0] ovf_q;

   logic [SPW-1:0] rd_sp, wr_sp;
   logic [LW-1:0]  rd_lvl, wr_lvl;
   logic           wr_full;

   assign rd_sp    = sp_q[rd_tid];
   assign rd_empty = (rd_sp == '0);
   assign rd_lvl   = LW'(rd_sp - SPW'(1));
   assign rd_entry = mem_q[rd_tid][rd_lvl];

   assign wr_sp    = sp_q[wr_tid];
   assign wr_full  = (wr_sp == SPW'(DEPTH));
   assign wr_lvl   = LW'(wr_sp);
   assign ovf      = ovf_q;

   always_ff @(posedge clk) begin
      if (wr_en && !wr_full)
         mem_q[wr_tid][wr_lvl] <= wr_entry;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q <= '0;
         for (int i = 0; i < NTHREADS; i++) sp_q[i] <= '0;
      end else begin
         for (int i = 0; i < NTHREADS; i++) begin
            if (clr_en && clr_tid == TIDW'(i)) begin
               sp_q[i]  <= '0;
               ovf_q[i] <= 1'b0;
            end else begin
               if (pop_en && rd_tid == TIDW'(i) && sp_q[i] != '0)
                  sp_q[i] <= sp_q[i] - SPW'(1);
               if (wr_en && wr_tid == TIDW'(i)) begin
                  if (wr_full) ovf_q[i] <= 1'b1;
                  else         sp_q[i]  <= sp_q[i] + SPW'(1);
               end
            end
         end
      end
   end

   // R11
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_full && !(clr_en && clr_tid == wr_tid)) |=> ovf_q[$past(wr_tid)]);

   // R10
   push_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_full && !(clr_en && clr_tid == wr_tid) && !(pop_en && rd_tid == wr_tid))
      |=> sp_q[$past(wr_tid)] == $past(wr_sp) + SPW'(1));

   generate
      for (genvar g = 0; g < NTHREADS; g++) begin : g_bound
         // R11
         sp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            sp_q[g] <= SPW'(DEPTH));
      end
   endgenerate

endmodule

// File: rtl/tts_step_decide.sv
module tts_step_decide import tts_pkg::*; #(
   parameter int RAYS        = 4,
   parameter int DW          = 32,
   parameter int AW          = 32,
   parameter bit DIST_SIGNED = 1'b0,
   localparam int VW         = RAYS * DW,
   localparam int EW         = AW + 2 * VW
) (
   input  logic [RAYS-1:0] mask,
   input  logic [RAYS-1:0] hit_l,
   input  logic [RAYS-1:0] hit_r,
   input  logic [VW-1:0]   near_l,
   input  logic [VW-1:0]   far_l,
   input  logic [VW-1:0]   near_r,
   input  logic [VW-1:0]   far_r,
   input  logic [AW-1:0]   addr_l,
   input  logic [AW-1:0]   addr_r,
   output step_e           act,
   output logic [AW-1:0]   next_addr,
   output logic [EW-1:0]   push_entry
);

   localparam int SW = (RAYS > 1) ? $clog2(RAYS) : 1;

   logic [SW-1:0] sel;
   logic [DW-1:0] nl_sel, nr_sel;
   logic          any_l, any_r, left_closer;

   always_comb begin
      sel = '0;
      for (int k = RAYS - 1; k >= 0; k--)
         if (mask[k]) sel = SW'(k);
   end

   assign nl_sel = near_l[sel*DW +: DW];
   assign nr_sel = near_r[sel*DW +: DW];
   assign any_l  = |(hit_l & mask);
   assign any_r  = |(hit_r & mask);

   generate
      if (DIST_SIGNED) begin : g_scmp
         assign left_closer = ($signed(nl_sel) <= $signed(nr_sel));
      end else begin : g_ucmp
         assign left_closer = (nl_sel <= nr_sel);
      end
   endgenerate

   always_comb begin
      act        = ACT_POP;
      next_addr  = '0;
      push_entry = '0;
      if (any_l && any_r) begin
         act = ACT_PUSH;
         if (left_closer) begin
            next_addr  = addr_l;
            push_entry = {addr_r, near_r, far_r};
         end else begin
            next_addr  = addr_r;
            push_entry = {addr_l, near_l, far_l};
         end
      end else if (any_l) begin
         act       = ACT_DESC;
         next_addr = addr_l;
      end else if (any_r) begin
         act       = ACT_DESC;
         next_addr = addr_r;
      end
   end

endmodule

// File: rtl/tts_step_ctrl.sv
module tts_step_ctrl import tts_pkg::*; #(
   parameter int NTHREADS    = 64,
   parameter int DEPTH       = 32,
   parameter int RAYS        = 4,
   parameter int AW          = 32,
   parameter int DW          = 32,
   parameter bit ROUND_R     = 1'b1,
   parameter bit DIST_SIGNED = 1'b0,
   localparam int TIDW       = $clog2(NTHREADS),
   localparam int VW         = RAYS * DW,
   localparam int EW         = AW + 2 * VW
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_valid,
   input  logic [TIDW-1:0]     start_tid,
   input  logic [AW-1:0]       start_addr,
   input  logic [RAYS-1:0]     start_mask,
   output logic                fetch_valid,
   input  logic                fetch_ready,
   output logic [TIDW-1:0]     fetch_tid,
   output logic [AW-1:0]       fetch_addr,
   output logic                fetch_pop,
   output logic [VW-1:0]       fetch_near,
   output logic [VW-1:0]       fetch_far,
   input  logic                resp_valid,
   input  logic [TIDW-1:0]     resp_tid,
   input  logic                resp_leaf,
   input  logic [AW-1:0]       resp_left_addr,
   input  logic [AW-1:0]       resp_right_addr,
   input  logic [RAYS-1:0]     resp_hit_left,
   input  logic [RAYS-1:0]     resp_hit_right,
   input  logic [VW-1:0]       resp_near_left,
   input  logic [VW-1:0]       resp_far_left,
   input  logic [VW-1:0]       resp_near_right,
   input  logic [VW-1:0]       resp_far_right,
   output logic                geom_valid,
   output logic [TIDW-1:0]     geom_tid,
   output logic [AW-1:0]       geom_addr,
   input  logic                geom_done_valid,
   input  logic [TIDW-1:0]     geom_done_tid,
   output logic                done_valid,
   output logic [TIDW-1:0]     done_tid,
   output logic [NTHREADS-1:0] ovf_flags
);

   generate
      if (NTHREADS < 2) begin : g_bad_threads
         $error("tts_step_ctrl: NTHREADS must be at least 2");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("tts_step_ctrl: DEPTH must be at least 2");
      end
      if (RAYS < 1 || DW < 1 || AW < 1) begin : g_bad_width
         $error("tts_step_ctrl: RAYS, DW and AW must be positive");
      end
   endgenerate

   tstate_e         state_q [NTHREADS];
   logic [AW-1:0]   addr_q  [NTHREADS];
   logic [RAYS-1:0] mask_q  [NTHREADS];

   logic [NTHREADS-1:0] rdy;
   logic                g_valid, g_pop, adv, issue, pop_en;
   logic [TIDW-1:0]     g_idx;
   logic [EW-1:0]       rd_entry, push_entry;
   logic                rd_empty, wr_en;
   logic                st_ok, rsp_ok, gd_ok;
   step_e               act;
   logic [AW-1:0]       next_addr;

   always_comb begin
      for (int i = 0; i < NTHREADS; i++)
         rdy[i] = (state_q[i] == TS_RDY_NODE) || (state_q[i] == TS_RDY_POP);
   end

   tts_rr_arb #(.N(NTHREADS), .ROUND_R(ROUND_R)) i_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (rdy),
      .adv      (adv),
      .gnt_valid(g_valid),
      .gnt_idx  (g_idx)
   );

   assign g_pop       = g_valid && (state_q[g_idx] == TS_RDY_POP);
   assign done_valid  = g_pop && rd_empty;
   assign done_tid    = g_idx;
   assign fetch_valid = g_valid && !(g_pop && rd_empty);
   assign fetch_tid   = g_idx;
   assign fetch_pop   = g_pop;
   assign fetch_addr  = g_pop ? rd_entry[EW-1 -: AW] : addr_q[g_idx];
   assign fetch_near  = g_pop ? rd_entry[2*VW-1 -: VW] : '0;
   assign fetch_far   = g_pop ? rd_entry[VW-1:0] : '0;
   assign issue       = fetch_valid && fetch_ready;
   assign adv         = issue || done_valid;
   assign pop_en      = issue && g_pop;

   assign st_ok  = start_valid && (state_q[start_tid] == TS_IDLE);
   assign rsp_ok = resp_valid && (state_q[resp_tid] == TS_WAIT_FETCH);
   assign gd_ok  = geom_done_valid && (state_q[geom_done_tid] == TS_WAIT_GEOM);

   assign geom_valid = rsp_ok && resp_leaf;
   assign geom_tid   = resp_tid;
   assign geom_addr  = addr_q[resp_tid];

   tts_step_decide #(.RAYS(RAYS), .DW(DW), .AW(AW), .DIST_SIGNED(DIST_SIGNED)) i_decide (
      .mask      (mask_q[resp_tid]),
      .hit_l     (resp_hit_left),
      .hit_r     (resp_hit_right),
      .near_l    (resp_near_left),
      .far_l     (resp_far_left),
      .near_r    (resp_near_right),
      .far_r     (resp_far_right),
      .addr_l    (resp_left_addr),
      .addr_r    (resp_right_addr),
      .act       (act),
      .next_addr (next_addr),
      .push_entry(push_entry)
   );

   assign wr_en = rsp_ok && !resp_leaf && (act == ACT_PUSH);

   tts_thread_stack #(.NTHREADS(NTHREADS), .DEPTH(DEPTH), .EW(EW)) i_stack (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_tid  (g_idx),
      .pop_en  (pop_en),
      .rd_entry(rd_entry),
      .rd_empty(rd_empty),
      .wr_en   (wr_en),
      .wr_tid  (resp_tid),
      .wr_entry(push_entry),
      .clr_en  (st_ok),
      .clr_tid (start_tid),
      .ovf     (ovf_flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NTHREADS; i++) begin
            state_q[i] <= TS_IDLE;
            addr_q[i]  <= '0;
            mask_q[i]  <= '0;
         end
      end else begin
         for (int i = 0; i < NTHREADS; i++) begin
            if (st_ok && start_tid == TIDW'(i)) begin
               state_q[i] <= TS_RDY_NODE;
               addr_q[i]  <= start_addr;
               mask_q[i]  <= start_mask;
            end
            if (done_valid && g_idx == TIDW'(i))
               state_q[i] <= TS_IDLE;
            if (issue && g_idx == TIDW'(i)) begin
               state_q[i] <= TS_WAIT_FETCH;
               if (g_pop) addr_q[i] <= rd_entry[EW-1 -: AW];
            end
            if (rsp_ok && resp_tid == TIDW'(i)) begin
               if (resp_leaf) begin
                  state_q[i] <= TS_WAIT_GEOM;
               end else if (act == ACT_POP) begin
                  state_q[i] <= TS_RDY_POP;
               end else begin
                  state_q[i] <= TS_RDY_NODE;
                  addr_q[i]  <= next_addr;
               end
            end
            if (gd_ok && geom_done_tid == TIDW'(i))
               state_q[i] <= TS_RDY_POP;
         end
      end
   end

   // R3
   issue_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && fetch_ready) |=> state_q[$past(fetch_tid)] == TS_WAIT_FETCH);

   // R6
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> state_q[$past(done_tid)] == TS_IDLE);

   // R7
   geom_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      geom_valid |=> state_q[$past(geom_tid)] == TS_WAIT_GEOM);

endmodule

// File: tb/test_tts_step_ctrl.sv
module test_tts_step_ctrl;

   localparam int NT    = 4;
   localparam int DEPTH = 4;
   localparam int RAYS  = 4;
   localparam int AW    = 16;
   localparam int DW    = 8;
   localparam int TIDW  = 2;
   localparam int VW    = RAYS * DW;
   localparam int NCYC  = 4000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic            start_valid = 0;
   logic [TIDW-1:0] start_tid = 0;
   logic [AW-1:0]   start_addr = 0;
   logic [RAYS-1:0] start_mask = 0;
   logic            fetch_valid, fetch_pop;
   logic            fetch_ready = 0;
   logic [TIDW-1:0] fetch_tid;
   logic [AW-1:0]   fetch_addr;
   logic [VW-1:0]   fetch_near, fetch_far;
   logic            resp_valid = 0, resp_leaf = 0;
   logic [TIDW-1:0] resp_tid = 0;
   logic [AW-1:0]   resp_left_addr = 0, resp_right_addr = 0;
   logic [RAYS-1:0] resp_hit_left = 0, resp_hit_right = 0;
   logic [VW-1:0]   resp_near_left = 0, resp_far_left = 0, resp_near_right = 0, resp_far_right = 0;
   logic            geom_valid, done_valid;
   logic [TIDW-1:0] geom_tid, done_tid;
   logic [AW-1:0]   geom_addr;
   logic            geom_done_valid = 0;
   logic [TIDW-1:0] geom_done_tid = 0;
   logic [NT-1:0]   ovf_flags;

   tts_step_ctrl #(.NTHREADS(NT), .DEPTH(DEPTH), .RAYS(RAYS), .AW(AW), .DW(DW)) i_tts_step_ctrl (
      .clk(clk), .rst_n(rst_n),
      .start_valid(start_valid), .start_tid(start_tid), .start_addr(start_addr), .start_mask(start_mask),
      .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_tid(fetch_tid), .fetch_addr(fetch_addr),
      .fetch_pop(fetch_pop), .fetch_near(fetch_near), .fetch_far(fetch_far),
      .resp_valid(resp_valid), .resp_tid(resp_tid), .resp_leaf(resp_leaf),
      .resp_left_addr(resp_left_addr), .resp_right_addr(resp_right_addr),
      .resp_hit_left(resp_hit_left), .resp_hit_right(resp_hit_right),
      .resp_near_left(resp_near_left), .resp_far_left(resp_far_left),
      .resp_near_right(resp_near_right), .resp_far_right(resp_far_right),
      .geom_valid(geom_valid), .geom_tid(geom_tid), .geom_addr(geom_addr),
      .geom_done_valid(geom_done_valid), .geom_done_tid(geom_done_tid),
      .done_valid(done_valid), .done_tid(done_tid), .ovf_flags(ovf_flags)
   );

   int n_tests = 0;
   int n_fail  = 0;

   // reference model: 0 idle, 1 ready-node, 2 ready-pop, 3 wait-fetch, 4 wait-geom
   int            mst   [NT];
   logic [AW-1:0] maddr [NT];
   logic [3:0]    mmask [NT];
   int            msp   [NT];
   bit            movf  [NT];
   string         why   [NT];
   logic [AW-1:0] sa    [NT][DEPTH];
   logic [VW-1:0] sn    [NT][DEPTH];
   logic [VW-1:0] sf    [NT][DEPTH];
   int            last_g = NT - 1;

   task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic drive();
      int r;
      int base;
      start_valid     = ($urandom % 4) == 0;
      start_tid       = TIDW'($urandom);
      start_addr      = AW'($urandom);
      start_mask      = (($urandom % 8) == 0) ? 4'h0 : RAYS'($urandom);
      fetch_ready     = ($urandom % 4) != 0;
      geom_done_valid = ($urandom % 3) == 0;
      geom_done_tid   = TIDW'($urandom);
      resp_valid      = 0;
      base            = $urandom % NT;
      for (int k = 0; k < NT; k++) begin
         if (!resp_valid && mst[(base + k) % NT] == 3 && ($urandom % 4) != 0) begin
            resp_valid = 1;
            resp_tid   = TIDW'((base + k) % NT);
         end
      end
      r               = $urandom % 10;
      resp_leaf       = (r < 3);
      resp_left_addr  = AW'($urandom);
      resp_right_addr = AW'($urandom);
      resp_hit_left   = RAYS'($urandom);
      resp_hit_right  = RAYS'($urandom);
      if (r >= 6) begin
         resp_hit_left  = 4'hF;
         resp_hit_right = 4'hF;
      end
      resp_near_left  = VW'($urandom);
      resp_far_left   = VW'($urandom);
      resp_near_right = (($urandom % 4) == 0) ? resp_near_left : VW'($urandom);
      resp_far_right  = VW'($urandom);
   endtask

   task automatic step();
      int  pst [NT];
      bit  g_v, g_pop, e_done, e_fv, e_geom;
      int  g;
      int  sel;
      bit  al, ar;
      logic [DW-1:0] nl, nr;
      for (int i = 0; i < NT; i++) pst[i] = mst[i];
      g_v = 0;
      g   = 0;
      for (int k = NT; k >= 1; k--) begin
         if (pst[(last_g + k) % NT] == 1 || pst[(last_g + k) % NT] == 2) begin
            g_v = 1;
            g   = (last_g + k) % NT;
         end
      end
      g_pop  = g_v && pst[g] == 2;
      e_done = g_pop && msp[g] == 0;
      e_fv   = g_v && !e_done;
      e_geom = resp_valid && pst[resp_tid] == 3 && resp_leaf;

      // R3 grant and issue
      chk(64'(fetch_valid), 64'(e_fv), "R3 fetch_valid");
      if (e_fv) begin
         chk(64'(fetch_tid), 64'(g), "R3 round-robin fetch_tid");
         chk(64'(fetch_pop), 64'(g_pop), {"R4/R5 fetch_pop after ", why[g]});
         if (g_pop) begin
            chk(64'(fetch_addr), 64'(sa[g][msp[g]-1]), {"R5 popped addr after ", why[g]});
            chk(64'(fetch_near), 64'(sn[g][msp[g]-1]), "R5 popped near");
            chk(64'(fetch_far),  64'(sf[g][msp[g]-1]), "R5 popped far");
         end else begin
            chk(64'(fetch_addr), 64'(maddr[g]), {"fetch_addr after ", why[g]});
            chk(64'(fetch_near), 64'(0), "R4 near zero");
            chk(64'(fetch_far),  64'(0), "R4 far zero");
         end
      end
      // R6 completion
      chk(64'(done_valid), 64'(e_done), "R6 done_valid");
      if (e_done) chk(64'(done_tid), 64'(g), "R6 done_tid");
      // R7 leaf hand-off
      chk(64'(geom_valid), 64'(e_geom), "R7 geom_valid");
      if (e_geom) begin
         chk(64'(geom_tid),  64'(resp_tid), "R7 geom_tid");
         chk(64'(geom_addr), 64'(maddr[resp_tid]), "R7 geom_addr");
      end
      // R11 sticky overflow
      for (int i = 0; i < NT; i++) chk(64'(ovf_flags[i]), 64'(movf[i]), "R11 ovf_flags");

      // model next state
      if (start_valid && pst[start_tid] == 0) begin
         mst[start_tid] = 1; maddr[start_tid] = start_addr; mmask[start_tid] = start_mask;
         msp[start_tid] = 0; movf[start_tid] = 0; why[start_tid] = "R2 start";
      end
      if (e_done) begin
         mst[g] = 0; last_g = g;
      end
      if (e_fv && fetch_ready) begin
         mst[g] = 3; last_g = g;
         if (g_pop) begin
            msp[g]--; maddr[g] = sa[g][msp[g]];
         end
      end
      if (resp_valid && pst[resp_tid] == 3) begin
         if (resp_leaf) mst[resp_tid] = 4;
         else begin
            sel = 0;
            for (int k = RAYS - 1; k >= 0; k--) if (mmask[resp_tid][k]) sel = k;
            al = |(resp_hit_left & mmask[resp_tid]);
            ar = |(resp_hit_right & mmask[resp_tid]);
            nl = resp_near_left[sel*DW +: DW];
            nr = resp_near_right[sel*DW +: DW];
            if (al && ar) begin
               mst[resp_tid] = 1;
               why[resp_tid] = (mmask[resp_tid] != 4'hF) ? "R10 closer child (R13 mask)" : "R10 closer child";
               if (msp[resp_tid] == DEPTH) movf[resp_tid] = 1;
               if (nl <= nr) begin
                  maddr[resp_tid] = resp_left_addr;
                  if (msp[resp_tid] < DEPTH) begin
                     sa[resp_tid][msp[resp_tid]] = resp_right_addr;
                     sn[resp_tid][msp[resp_tid]] = resp_near_right;
                     sf[resp_tid][msp[resp_tid]] = resp_far_right;
                     msp[resp_tid]++;
                  end
               end else begin
                  maddr[resp_tid] = resp_right_addr;
                  if (msp[resp_tid] < DEPTH) begin
                     sa[resp_tid][msp[resp_tid]] = resp_left_addr;
                     sn[resp_tid][msp[resp_tid]] = resp_near_left;
                     sf[resp_tid][msp[resp_tid]] = resp_far_left;
                     msp[resp_tid]++;
                  end
               end
            end else if (al || ar) begin
               mst[resp_tid]   = 1;
               maddr[resp_tid] = al ? resp_left_addr : resp_right_addr;
               why[resp_tid]   = (mmask[resp_tid] != 4'hF) ? "R9 one child (R13 mask)" : "R9 one child";
            end else begin
               mst[resp_tid] = 2;
               why[resp_tid] = "R8 no hit";
            end
         end
      end
      if (geom_done_valid && pst[geom_done_tid] == 4) begin
         mst[geom_done_tid] = 2;
         why[geom_done_tid] = "R12 geometry done";
      end
   endtask

   initial begin
      for (int i = 0; i < NT; i++) begin
         mst[i] = 0; maddr[i] = 0; mmask[i] = 0; msp[i] = 0; movf[i] = 0; why[i] = "reset";
      end
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(64'(fetch_valid), 64'(0), "R1 fetch_valid in reset");
      chk(64'(done_valid),  64'(0), "R1 done_valid in reset");
      chk(64'(geom_valid),  64'(0), "R1 geom_valid in reset");
      chk(64'(ovf_flags),   64'(0), "R1 ovf_flags in reset");
      for (int c = 0; c < NCYC; c++) begin
         @(negedge clk);
         if (c == 0) rst_n = 1'b1;
         drive();
         #1;
         step();
      end
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule